// File: doc/BRIEF.md
# Four-Slot Alarm Match Bank

This block holds a small set of alarm times, each made of an hour, a minute and an AM/PM flag, and watches the time of day supplied by the surrounding clock logic. Whenever the supplied time begins to equal a stored alarm time and that alarm's enable switch is on, the alarm's match flag is raised. The flag stays up, driving a match LED, until a snooze press made while the device is in its home screen clears every raised flag at once. A second output vector copies the enable switches so that they can drive status LEDs.

Alarm times are written one slot at a time. The slot is picked by an index, and a single-cycle load strobe writes it. The comparison uses whole minutes only. The flag is raised when equality begins, not for as long as it lasts. A snooze inside the alarm minute therefore silences the alarm for that minute, and the alarm rings again the next time the time of day reaches its setting.

Top module: `alm_bank`

## Requirements
- R1: While reset is low and after it is released, every bit of `hit_o` is 0, every stored alarm is 0:00 AM, and no alarm fires on the first clock edge after release.
- R2: When `ld_stb` is high at a clock edge, only the slot numbered `ld_idx` takes the time on `ld_hour`/`ld_min`/`ld_pm`. An index with no slot is ignored. A slot loaded with the current time raises its flag on the second edge after the load.
- R3: Bit i of `hit_o` is set at the clock edge where the current hour, minute and AM/PM flag first all equal the values stored in slot i. A difference in any one of the three, including AM versus PM alone, prevents the match.
- R4: A raised bit of `hit_o` stays high while the time of day moves on. It falls only on an edge where `snooze` and `home_mode` are both high.
- R5: An alarm whose `arm_sw` bit is low at the edge where its match begins does not raise its flag.
- R6: `snooze` together with `home_mode` clears all bits of `hit_o` at the next edge. `snooze` with `home_mode` low has no effect.
- R7: After a snooze, an alarm does not fire again while its minute is still current. It fires again when the time leaves that value and later returns to it.
- R8: An alarm that is enabled while its matching minute is already current does not fire during that minute.
- R9: If a snooze clear and the start of a match fall on the same edge, the matching alarm's bit ends high and all other bits end low.
- R10: `armed_o` equals `arm_sw` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_hour | input | 4 | Current hour of day (1 to 12) |
| cur_min | input | 6 | Current minute (0 to 59) |
| cur_pm | input | 1 | Current half of the day, 1 = PM |
| ld_stb | input | 1 | Load strobe for one alarm slot |
| ld_idx | input | 2 | Slot number to load |
| ld_hour | input | 4 | Hour to store |
| ld_min | input | 6 | Minute to store |
| ld_pm | input | 1 | AM/PM flag to store, 1 = PM |
| arm_sw | input | 4 | Per-alarm enable switches |
| home_mode | input | 1 | High while the device is in its home screen |
| snooze | input | 1 | Snooze button pulse |
| hit_o | output | 4 | Sticky match flags, one per alarm |
| armed_o | output | 4 | Enable status, a copy of the switches |

## Verification
The hardest cases to reach from the ports are those where the time of day does not change but the outcome must: a snooze inside an alarm's own minute, and a switch enabled inside it. The stimulus holds the time at a matching value over several cycles after each such event and expects no flag. It then steps the time away and back to show that the alarm fires once more. Two further cases need particular cycle placement. In one, a snooze is placed on the same cycle in which a different alarm's minute begins. In the other, a slot is loaded with the time that is already current, so that the flag appears one edge after the write.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int HOUR_W = 4;
    localparam int MIN_W  = 6;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic              pm;
    } alm_time_t;
endpackage

// File: rtl/alm_ld_dec.sv
module alm_ld_dec #(
    parameter int N_ALM = 4,
    parameter int IDX_W = 2
) (
    input  logic             stb_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N_ALM-1:0] we_o
);
    for (genvar g = 0; g < N_ALM; g++) begin : g_we
        assign we_o[g] = stb_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/alm_slot.sv
module alm_slot
    import alm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  alm_time_t now_i,
    input  logic      wr_i,
    input  alm_time_t wr_time_i,
    input  logic      arm_i,
    input  logic      clr_i,
    output logic      hit_o
);
    typedef struct packed {
        alm_time_t tm;
        logic      eq_seen;
        logic      hit;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     eq_now;
    logic     onset;

    always_comb begin
        st_d       = st_q;
        eq_now     = (st_q.tm == now_i);
        onset      = eq_now && !st_q.eq_seen;
        st_d.eq_seen = eq_now;
        if (wr_i) begin
            st_d.tm = wr_time_i;
        end
        if (clr_i) begin
            st_d.hit = 1'b0;
        end
        if (onset && arm_i) begin
            st_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tm      <= '0;
            st_q.eq_seen <= 1'b1;
            st_q.hit     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = st_q.hit;
endmodule

// File: rtl/alm_bank.sv
module alm_bank
    import alm_pkg::*;
#(
    parameter int N_ALM = 4,
    localparam int IDX_W = (N_ALM > 1) ? $clog2(N_ALM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic              cur_pm,
    input  logic              ld_stb,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [HOUR_W-1:0] ld_hour,
    input  logic [MIN_W-1:0]  ld_min,
    input  logic              ld_pm,
    input  logic [N_ALM-1:0]  arm_sw,
    input  logic              home_mode,
    input  logic              snooze,
    output logic [N_ALM-1:0]  hit_o,
    output logic [N_ALM-1:0]  armed_o
);
    alm_time_t          now_t;
    alm_time_t          ld_t;
    logic [N_ALM-1:0]   slot_we;
    logic               snz_clr;

    assign now_t   = '{hour: cur_hour, minute: cur_min, pm: cur_pm};
    assign ld_t    = '{hour: ld_hour, minute: ld_min, pm: ld_pm};
    assign snz_clr = snooze && home_mode;
    assign armed_o = arm_sw;

    alm_ld_dec #(
        .N_ALM (N_ALM),
        .IDX_W (IDX_W)
    ) u_dec (
        .stb_i (ld_stb),
        .idx_i (ld_idx),
        .we_o  (slot_we)
    );

    for (genvar g = 0; g < N_ALM; g++) begin : g_slot
        alm_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .now_i     (now_t),
            .wr_i      (slot_we[g]),
            .wr_time_i (ld_t),
            .arm_i     (arm_sw[g]),
            .clr_i     (snz_clr),
            .hit_o     (hit_o[g])
        );
    end
endmodule

// File: rtl/alm_bank_chk.sv
module alm_bank_chk
    import alm_pkg::*;
#(
    parameter int N_ALM = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HOUR_W-1:0] cur_hour,
    input logic [MIN_W-1:0]  cur_min,
    input logic              cur_pm,
    input logic              ld_stb,
    input logic [N_ALM-1:0]  arm_sw,
    input logic              home_mode,
    input logic              snooze,
    input logic [N_ALM-1:0]  hit_o
);
    // R5: a flag can only rise for an alarm whose switch was on
    p_armed_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((hit_o & ~$past(hit_o) & ~$past(arm_sw)) == '0));

    // R4: a raised flag only falls after a home-mode snooze
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(hit_o) & ~hit_o)) |-> $past(snooze && home_mode));

    // R6: with a steady time and no load, a home snooze empties the vector
    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snooze && home_mode && !ld_stb && !$past(ld_stb)
         && $stable({cur_hour, cur_min, cur_pm})) |=> (hit_o == '0));

    // R8: a new flag needs a change of time or a load two cycles before
    p_onset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_o & ~$past(hit_o))) |->
            (($past({cur_hour, cur_min, cur_pm}) != $past({cur_hour, cur_min, cur_pm}, 2))
             || $past(ld_stb, 2)));
endmodule

bind alm_bank alm_bank_chk #(.N_ALM(N_ALM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_hour  (cur_hour),
    .cur_min   (cur_min),
    .cur_pm    (cur_pm),
    .ld_stb    (ld_stb),
    .arm_sw    (arm_sw),
    .home_mode (home_mode),
    .snooze    (snooze),
    .hit_o     (hit_o)
);

// File: tb/tb_alm_bank.sv
module tb_alm_bank;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cur_hour = 4'd3;
    logic [5:0] cur_min = 6'd30;
    logic       cur_pm = 1'b0;
    logic       ld_stb = 1'b0;
    logic [1:0] ld_idx = '0;
    logic [3:0] ld_hour = '0;
    logic [5:0] ld_min = '0;
    logic       ld_pm = 1'b0;
    logic [3:0] arm_sw = 4'b1111;
    logic       home_mode = 1'b1;
    logic       snooze = 1'b0;
    logic [3:0] hit_o;
    logic [3:0] armed_o;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] q_exp[$];
    string      q_tag[$];

    alm_bank dut (
        .clk(clk), .rst_n(rst_n),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_pm(cur_pm),
        .ld_stb(ld_stb), .ld_idx(ld_idx), .ld_hour(ld_hour), .ld_min(ld_min), .ld_pm(ld_pm),
        .arm_sw(arm_sw), .home_mode(home_mode), .snooze(snooze),
        .hit_o(hit_o), .armed_o(armed_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check_armed(input string tag);
        n_run++;
        if (armed_o !== arm_sw) begin
            n_fail++;
            $display("FAIL %s armed_o actual=%b expected=%b", tag, armed_o, arm_sw);
        end
    endtask

    // one cycle of time-of-day stimulus, expected flags after its edge
    task automatic cyc(input logic [3:0] h, input logic [5:0] m, input logic p,
                       input logic [3:0] arm, input logic home, input logic snz,
                       input logic [3:0] exp, input string tag);
        @(negedge clk);
        ld_stb = 1'b0; cur_hour = h; cur_min = m; cur_pm = p;
        arm_sw = arm; home_mode = home; snooze = snz;
        @(posedge clk);
        #1;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        check_armed("R10");
    endtask

    task automatic load(input logic [1:0] idx, input logic [3:0] h, input logic [5:0] m,
                        input logic p, input logic [3:0] exp, input string tag);
        @(negedge clk);
        ld_stb = 1'b1; ld_idx = idx; ld_hour = h; ld_min = m; ld_pm = p;
        snooze = 1'b0;
        @(posedge clk);
        #1;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    // monitor: compare each expected item one half cycle after its edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                logic [3:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_run++;
                if (hit_o !== e) begin
                    n_fail++;
                    $display("FAIL %s hit_o actual=%b expected=%b", t, hit_o, e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (hit_o !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1 hit_o in reset actual=%b expected=0000", hit_o);
        end
        rst_n = 1'b1;
        cyc(4'd3, 6'd30, 1'b0, 4'b1111, 1'b1, 1'b0, 4'b0000, "R1");
        load(2'd0, 4'd7, 6'd15, 1'b1, 4'b0000, "R2");
        load(2'd1, 4'd7, 6'd15, 1'b0, 4'b0000, "R2");
        load(2'd2, 4'd8, 6'd0,  1'b1, 4'b0000, "R2");
        load(2'd3, 4'd7, 6'd16, 1'b1, 4'b0000, "R2");
        cyc(4'd3, 6'd30, 1'b0, 4'b1111, 1'b1, 1'b0, 4'b0000, "R1");
        // basic match, AM slot must stay quiet
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0001, "R3");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0001, "R4");
        cyc(4'd7, 6'd16, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b1001, "R3");
        cyc(4'd7, 6'd17, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b1001, "R4");
        // snooze outside home, then in home
        cyc(4'd7, 6'd17, 1'b1, 4'b1111, 1'b0, 1'b1, 4'b1001, "R6");
        cyc(4'd7, 6'd17, 1'b1, 4'b1111, 1'b1, 1'b1, 4'b0000, "R6");
        // snooze inside the alarm minute
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0001, "R3");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b1, 4'b0000, "R6");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0000, "R7");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0000, "R7");
        cyc(4'd7, 6'd16, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b1000, "R7");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b1001, "R7");
        cyc(4'd7, 6'd20, 1'b1, 4'b1111, 1'b1, 1'b1, 4'b0000, "R6");
        // disabled alarm, then enabled mid-minute
        cyc(4'd7, 6'd15, 1'b1, 4'b1110, 1'b1, 1'b0, 4'b0000, "R5");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0000, "R8");
        // partial mismatches
        cyc(4'd8, 6'd1,  1'b1, 4'b1111, 1'b1, 1'b0, 4'b0000, "R3");
        cyc(4'd8, 6'd0,  1'b0, 4'b1111, 1'b1, 1'b0, 4'b0000, "R3");
        cyc(4'd8, 6'd0,  1'b1, 4'b1111, 1'b1, 1'b0, 4'b0100, "R3");
        // clear and new match on the same edge
        cyc(4'd7, 6'd15, 1'b0, 4'b1111, 1'b1, 1'b1, 4'b0010, "R9");
        // reload one slot, others untouched
        load(2'd1, 4'd9, 6'd45, 1'b0, 4'b0010, "R2");
        cyc(4'd7, 6'd15, 1'b0, 4'b1111, 1'b1, 1'b1, 4'b0000, "R2");
        cyc(4'd9, 6'd45, 1'b0, 4'b1111, 1'b1, 1'b0, 4'b0010, "R2");
        cyc(4'd7, 6'd15, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0011, "R2");
        // load the time that is already current
        cyc(4'd9, 6'd0,  1'b0, 4'b1111, 1'b1, 1'b1, 4'b0000, "R6");
        load(2'd2, 4'd9, 6'd0, 1'b0, 4'b0000, "R2");
        cyc(4'd9, 6'd0,  1'b0, 4'b1111, 1'b1, 1'b0, 4'b0100, "R2");
        cyc(4'd9, 6'd1,  1'b0, 4'b0101, 1'b1, 1'b0, 4'b0100, "R10");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule